// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block creates the serial clock and the active-low chip select for the master side of an SPI link. A data engine beside it sets up a timing word, an idle-gap length, the clock polarity and phase, the number of bits and a keep-selected flag, then pulses `start`. The block lowers chip select, waits a programmable setup time, clocks out the requested number of bits with separately programmable high and low half-periods, waits a hold time, releases chip select and keeps it released for a minimum gap. When that gap is over it pulses `done`.

The data engine does not watch the serial clock itself. It moves its shift register on `shift_stb` and captures input data on `sample_stb`. Each strobe is one system-clock cycle wide and lines up with the serial clock edge it belongs to. When keep-selected is set, the transfer ends right after the last bit. Chip select stays low, so the next transfer continues the same selection without a hold or gap. Every interval is counted in system-clock cycles and is written as the cycle count minus one.

Top module: `sclk_csel_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `cs_n` is 1, `done`, `shift_stb` and `sample_stb` are 0, and `sck` equals `cpol`.
- R2: The timing word carries the setup count in bits 31:24, the hold count in 23:16, the low count in 15:8 and the high count in 7:0. Each field value v means v+1 cycles. From the first cycle with `cs_n` low, the first `sck` edge comes after setup+1 cycles.
- R3: Each bit keeps `sck` high for high+1 cycles and low for low+1 cycles. Across a transfer, `sck` spends exactly N times (active-level count + 1) cycles away from `cpol`.
- R4: `cpol` sets the idle level of `sck`. Whenever no bit is being clocked, `sck` equals `cpol`, and always when `cs_n` is high.
- R5: `bit_count_m1` = N-1 requests N bits, and exactly N `sample_stb` pulses occur. With `cpha` = 0 they fall on leading edges (away from idle). With `cpha` = 1 they fall on trailing edges (back to idle).
- R6: With `cpha` = 1, `shift_stb` pulses on every leading edge (N pulses). With `cpha` = 0, it pulses on every trailing edge except the last (N-1 pulses). The two strobes never coincide, and each occurs in the cycle its `sck` edge appears.
- R7: After the last bit, `cs_n` stays low for hold+1 further cycles with `sck` at idle. It rises with no strobe and no `sck` change.
- R8: After the hold, `cs_n` stays high for `gap_len`+1 cycles before `done`. A `start` that arrives while a transfer or its gap is in progress is ignored.
- R9: `done` is a single-cycle pulse. Counting from the first cycle after `start` is taken, it appears after setup+1 + N*(high+low+2) + hold+1 + gap+1 cycles, or after setup+1 + N*(high+low+2) cycles when keep-selected is set.
- R10: With `keep_sel` high when the last bit ends, `cs_n` stays low through `done` and the idle time that follows. A following `start` runs a full setup interval again, and `cs_n` never rises in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 4*FIELD_W | Setup, hold, low and high counts, each cycles minus one |
| gap_len | input | FIELD_W | Minimum deselected time, cycles minus one |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| start | input | 1 | Begins a transfer when idle |
| bit_count_m1 | input | BITCNT_W | Number of bits minus one |
| keep_sel | input | 1 | Keep chip select low at the end of the transfer |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| shift_stb | output | 1 | One-cycle request to present the next output bit |
| sample_stb | output | 1 | One-cycle request to capture the input bit |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench targets phase lengths at both ends of the 8-bit field range (all zero, and a 255 high count) and single-bit transfers. A design that misreads the minus-one encoding, or swaps the high and low fields under `cpol` = 1, shows up as a latency or active-cycle mismatch. Both phase settings are counted strobe by strobe, so an extra shift after the final trailing edge, or a sample placed on the wrong edge, is caught. A keep-selected transfer followed by a normal one catches a chip select that rises between them or skips setup. Start pulses injected mid-transfer and in the last gap cycle catch a design that queues or re-arms early.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LEAD,
      ST_TRAIL,
      ST_HOLD,
      ST_GAP
   } sct_state_e;

   typedef enum logic [1:0] {
      EDGE_NONE,
      EDGE_LEAD,
      EDGE_TRAIL
   } sct_edge_e;

endpackage

// File: rtl/sct_phase_timer.sv
`timescale 1ns/1ps
// Down counter for one phase; expired marks the final cycle of the phase.
module sct_phase_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sct_bit_tracker.sv
`timescale 1ns/1ps
// Counts bits still to be clocked; last is high during the final bit.
module sct_bit_tracker #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic         last
);
   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (load)
         left_q <= load_val;
      else if (step && left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign last = (left_q == '0);
endmodule

// File: rtl/sct_edge_strobes.sv
`timescale 1ns/1ps
// Maps a serial clock edge to shift and sample requests by phase mode.
module sct_edge_strobes
   import sct_pkg::*;
(
   input  sct_edge_e edge_kind,
   input  logic      cpha,
   input  logic      last_bit,
   output logic      shift_stb,
   output logic      sample_stb
);
   logic on_lead, on_trail;

   assign on_lead  = (edge_kind == EDGE_LEAD);
   assign on_trail = (edge_kind == EDGE_TRAIL);

   always_comb begin
      if (cpha) begin
         shift_stb  = on_lead;
         sample_stb = on_trail;
      end else begin
         shift_stb  = on_trail && !last_bit;
         sample_stb = on_lead;
      end
   end
endmodule

// File: rtl/sclk_csel_sequencer.sv
`timescale 1ns/1ps
module sclk_csel_sequencer
   import sct_pkg::*;
#(
   parameter int FIELD_W  = 8,
   parameter int BITCNT_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [4*FIELD_W-1:0]  timing_word,
   input  logic [FIELD_W-1:0]    gap_len,
   input  logic                  cpol,
   input  logic                  cpha,
   input  logic                  start,
   input  logic [BITCNT_W-1:0]   bit_count_m1,
   input  logic                  keep_sel,
   output logic                  sck,
   output logic                  cs_n,
   output logic                  shift_stb,
   output logic                  sample_stb,
   output logic                  done
);
   localparam int HI_LSB    = 0;
   localparam int LO_LSB    = FIELD_W;
   localparam int HOLD_LSB  = 2 * FIELD_W;
   localparam int SETUP_LSB = 3 * FIELD_W;

   if (FIELD_W < 1 || FIELD_W > 16) begin : g_bad_field_w
      $error("FIELD_W must lie in 1..16");
   end
   if (BITCNT_W < 1 || BITCNT_W > 16) begin : g_bad_bitcnt_w
      $error("BITCNT_W must lie in 1..16");
   end

   sct_state_e           state_q, state_d;
   sct_edge_e            edge_q, edge_d;
   logic [FIELD_W-1:0]   hi_q, lo_q, hold_q, gap_q;
   logic                 cpol_q, cpha_q;
   logic                 sel_q, sel_d;
   logic                 done_q, done_d;

   logic                 ph_load;
   logic [FIELD_W-1:0]   ph_val;
   logic                 ph_expired;
   logic                 bit_load, bit_step, bit_last;
   logic [FIELD_W-1:0]   lead_len, trail_len;
   logic                 take_start;

   assign take_start = (state_q == ST_IDLE) && start;
   assign lead_len   = cpol_q ? lo_q : hi_q;
   assign trail_len  = cpol_q ? hi_q : lo_q;

   sct_phase_timer #(.W(FIELD_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .expired  (ph_expired)
   );

   sct_bit_tracker #(.W(BITCNT_W)) u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bit_load),
      .load_val (bit_count_m1),
      .step     (bit_step),
      .last     (bit_last)
   );

   sct_edge_strobes u_strobe (
      .edge_kind  (edge_q),
      .cpha       (cpha_q),
      .last_bit   (bit_last),
      .shift_stb  (shift_stb),
      .sample_stb (sample_stb)
   );

   always_comb begin
      state_d  = state_q;
      edge_d   = EDGE_NONE;
      sel_d    = sel_q;
      done_d   = 1'b0;
      ph_load  = 1'b0;
      ph_val   = '0;
      bit_load = 1'b0;
      bit_step = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d  = ST_SETUP;
               ph_load  = 1'b1;
               ph_val   = timing_word[SETUP_LSB +: FIELD_W];
               bit_load = 1'b1;
               sel_d    = 1'b1;
            end
         end
         ST_SETUP: begin
            if (ph_expired) begin
               state_d = ST_LEAD;
               ph_load = 1'b1;
               ph_val  = lead_len;
               edge_d  = EDGE_LEAD;
            end
         end
         ST_LEAD: begin
            if (ph_expired) begin
               state_d = ST_TRAIL;
               ph_load = 1'b1;
               ph_val  = trail_len;
               edge_d  = EDGE_TRAIL;
            end
         end
         ST_TRAIL: begin
            if (ph_expired) begin
               if (!bit_last) begin
                  state_d  = ST_LEAD;
                  ph_load  = 1'b1;
                  ph_val   = lead_len;
                  edge_d   = EDGE_LEAD;
                  bit_step = 1'b1;
               end else if (keep_sel) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  state_d = ST_HOLD;
                  ph_load = 1'b1;
                  ph_val  = hold_q;
               end
            end
         end
         ST_HOLD: begin
            if (ph_expired) begin
               state_d = ST_GAP;
               ph_load = 1'b1;
               ph_val  = gap_q;
               sel_d   = 1'b0;
            end
         end
         ST_GAP: begin
            if (ph_expired) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         edge_q  <= EDGE_NONE;
         sel_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         edge_q  <= edge_d;
         sel_q   <= sel_d;
         done_q  <= done_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         hold_q <= '0;
         gap_q  <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
      end else if (take_start) begin
         hi_q   <= timing_word[HI_LSB   +: FIELD_W];
         lo_q   <= timing_word[LO_LSB   +: FIELD_W];
         hold_q <= timing_word[HOLD_LSB +: FIELD_W];
         gap_q  <= gap_len;
         cpol_q <= cpol;
         cpha_q <= cpha;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_IDLE: sck = cpol;
         ST_LEAD: sck = ~cpol_q;
         default: sck = cpol_q;
      endcase
   end

   assign cs_n = ~sel_q;
   assign done = done_q;
endmodule

// File: rtl/sct_checker.sv
`timescale 1ns/1ps
module sct_checker (
   input logic clk,
   input logic rst_n,
   input logic cpol,
   input logic sck,
   input logic cs_n,
   input logic shift_stb,
   input logic sample_stb,
   input logic done
);
   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sck == cpol));

   assert_strobe_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb || shift_stb) |-> (sck != $past(sck)));

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_stb && sample_stb));

   assert_cs_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> ($stable(sck) && !shift_stb && !sample_stb));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_keep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cs_n) |=> !cs_n);
endmodule

bind sclk_csel_sequencer sct_checker u_sct_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpol       (cpol),
   .sck        (sck),
   .cs_n       (cs_n),
   .shift_stb  (shift_stb),
   .sample_stb (sample_stb),
   .done       (done)
);

// File: tb/tb_sclk_csel_sequencer.sv
`timescale 1ns/1ps
module tb_sclk_csel_sequencer;
   localparam int FW = 8;
   localparam int BW = 10;

   typedef struct packed {
      logic [7:0] hi, lo, hold, setup, gap, nbm1;
      logic       cpol, cpha, keep;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{8'd0,   8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0},
      '{8'd1,   8'd1, 8'd3, 8'd3, 8'd3, 8'd7, 1'b0, 1'b0, 1'b0},
      '{8'd2,   8'd0, 8'd1, 8'd4, 8'd2, 8'd3, 1'b1, 1'b0, 1'b0},
      '{8'd0,   8'd3, 8'd2, 8'd1, 8'd5, 8'd4, 1'b0, 1'b1, 1'b0},
      '{8'd1,   8'd2, 8'd0, 8'd2, 8'd1, 8'd2, 1'b1, 1'b1, 1'b0},
      '{8'd255, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0},
      '{8'd3,   8'd3, 8'd5, 8'd5, 8'd5, 8'd1, 1'b0, 1'b0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4*FW-1:0] timing_word = '0;
   logic [FW-1:0] gap_len = '0;
   logic          cpol = 1'b0, cpha = 1'b0, start = 1'b0, keep_sel = 1'b0;
   logic [BW-1:0] bit_count_m1 = '0;
   logic          sck, cs_n, shift_stb, sample_stb, done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sclk_csel_sequencer #(.FIELD_W(FW), .BITCNT_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .timing_word(timing_word), .gap_len(gap_len),
      .cpol(cpol), .cpha(cpha), .start(start), .bit_count_m1(bit_count_m1),
      .keep_sel(keep_sel), .sck(sck), .cs_n(cs_n), .shift_stb(shift_stb),
      .sample_stb(sample_stb), .done(done)
   );

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_xfer(input vec_t v, input bit poke);
      int n       = int'(v.nbm1) + 1;
      int lead    = v.cpol ? int'(v.lo) : int'(v.hi);
      int body    = int'(v.setup) + 1 + n * (int'(v.hi) + int'(v.lo) + 2);
      int exp_lat = body + (v.keep ? 0 : int'(v.hold) + 1 + int'(v.gap) + 1);
      int exp_lo  = v.keep ? body + 1 : body + int'(v.hold) + 1;
      int cs_low = 0, cs_hi = 0, act = 0, first_edge = -1;
      int samp = 0, shf = 0, bad_edge = 0, lat = -1;
      logic prev_sck;
      @(negedge clk);
      timing_word  = {v.setup, v.hold, v.lo, v.hi};
      gap_len      = v.gap;
      cpol         = v.cpol;
      cpha         = v.cpha;
      keep_sel     = v.keep;
      bit_count_m1 = BW'(v.nbm1);
      start        = 1'b1;
      prev_sck     = v.cpol;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4000 && lat < 0; i++) begin
         start = poke && (i == 3 || i == exp_lat - 1);
         if (!cs_n) cs_low++;
         if (cs_n && !done) cs_hi++;
         if (sck != v.cpol) act++;
         if (first_edge < 0 && sck != v.cpol) first_edge = i;
         if (sample_stb) begin
            samp++;
            if (sck == prev_sck) bad_edge++;
            if ((sck != v.cpol) == v.cpha) bad_edge++;
         end
         if (shift_stb) begin
            shf++;
            if (sck == prev_sck) bad_edge++;
            if ((sck != v.cpol) != v.cpha) bad_edge++;
         end
         if (done) lat = i;
         prev_sck = sck;
         if (lat < 0) @(negedge clk);
      end
      start = 1'b0;
      check_eq("R9",  "start-to-done latency", lat, exp_lat);
      check_eq("R2",  "setup cycles before first edge", first_edge, int'(v.setup) + 1);
      check_eq("R3",  "active-level sck cycles", act, n * (lead + 1));
      check_eq("R5",  "sample strobes", samp, n);
      check_eq("R6",  "shift strobes", shf, v.cpha ? n : n - 1);
      check_eq("R6",  "strobes off their edge", bad_edge, 0);
      check_eq("R7",  "cs_n low cycles", cs_low, exp_lo);
      check_eq("R8",  "deselected gap cycles", cs_hi, v.keep ? 0 : int'(v.gap) + 1);
      check_eq("R4",  "sck at idle when done", sck, v.cpol);
      check_eq("R10", "cs_n level at done", cs_n, !v.keep);
      @(negedge clk);
      check_eq("R9",  "done width", done, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, with both clock polarities
      repeat (3) @(negedge clk);
      check_eq("R1", "cs_n in reset", cs_n, 1);
      check_eq("R1", "done in reset", done, 0);
      check_eq("R1", "strobes in reset", shift_stb | sample_stb, 0);
      check_eq("R1", "sck in reset, cpol 0", sck, 0);
      cpol = 1'b1;
      #1;
      check_eq("R4", "sck follows cpol 1 when idle", sck, 1);
      cpol = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "cs_n after reset", cs_n, 1);

      // table of transfers; the last one keeps chip select low
      for (int k = 0; k < NVEC; k++) run_xfer(VECS[k], 1'b0);

      // R10: selection held while idle, then a normal transfer follows
      for (int j = 0; j < 5; j++) begin
         check_eq("R10", "cs_n held low while idle", cs_n, 0);
         check_eq("R4",  "sck idle while held", sck, VECS[6].cpol);
         @(negedge clk);
      end
      run_xfer(VECS[1], 1'b0);

      // R8: starts during a transfer and in its last gap cycle are ignored
      run_xfer(VECS[2], 1'b1);
      for (int j = 0; j < 8; j++) begin
         check_eq("R8", "no transfer from ignored start", cs_n, 1);
         @(negedge clk);
      end

      // R1: reset mid-transfer returns to the deselected state at once
      timing_word = {8'd3, 8'd3, 8'd3, 8'd3};
      bit_count_m1 = BW'(5);
      keep_sel = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      check_eq("R1", "cs_n low before mid reset", cs_n, 0);
      rst_n = 1'b0;
      #1;
      check_eq("R1", "cs_n after mid-transfer reset", cs_n, 1);
      check_eq("R1", "sck after mid-transfer reset", sck, cpol);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R1", "done stays low after reset", done, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule